// File: doc/BRIEF.md
# Indexed Display Mode Register Port

This block is the register file of a display adapter that software reaches through a pair of 32-bit ports. A write to the index port selects a register, and the value port then reads or writes the selected register. A third port is a firmware mailbox that reads as zero and ignores writes. Before software relies on the register set, it negotiates an interface version through the identification register. The block range-checks every mode setting it receives. It holds the display geometry, the enable and configured flags, a synchronisation handshake, the guest identifier, the hardware cursor controls and a small bank of scratch words.

The rest of the device reads the mode and cursor state from dedicated outputs. The display engine raises `sync_done` when it has finished the work that a sync request asked for, and this clears the busy flag that software polls. A read returns its data on `rsp_data` one clock after the request, with `rsp_valid` high for that clock. Register indices are decoded from the full 32-bit index. The palette window is accepted but not stored. Scratch words sit directly above the palette window.

Top module: `dispreg_port`

## Requirements
- R1: After reset, the identification register reads 0x90000002, width is 640, height is 480, enable, configured, busy, cursor visible and the error flag are 0.
- R2: Port 0 stores the index and reads it back. Port 2 reads 0 and ignores writes. Port 3 reads 0xFFFFFFFF. Every read answers one cycle later with `rsp_valid` high.
- R3: A write to index 0 is kept only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R4: A width write (index 2) is kept when it is no more than MAX_WIDTH (2368). A height write (index 3) is kept when it is no more than MAX_HEIGHT (1770). Larger values are dropped.
- R5: Index 6 reads 24 when the host depth is 32, and the host depth otherwise. Index 7 reads the host depth. Writes to either index change nothing.
- R6: Index 12 reads host depth × width / 8.
- R7: Index 17 reads 0xE3 (fill bit 0, copy bit 1, cursor bits 5, 6 and 7). Index 4 reads MAX_WIDTH and index 5 reads MAX_HEIGHT.
- R8: Index 1 (enable) and index 20 (configured) store whether the written value is nonzero. They drive `mode_enable` and `mode_configured`.
- R9: A nonzero write to index 21 sets busy. A pulse on `sync_done` clears it. Indices 21 and 22 read busy.
- R10: Indices 24, 25 and 26 store the cursor id, x and y. Writing 0 to index 27 hides the cursor and writing 1 shows it, each with a one-cycle `cursor_update` pulse. Any other value changes nothing and gives no pulse.
- R11: Indices 1024 to 1791 read 0, ignore writes and are not errors. Indices 1792 up to 1792+SCRATCH_SIZE-1 read and write scratch words.
- R12: An access through port 1 to an index that is not mapped for that direction reads 0 and sets `reg_error`. Only reset clears `reg_error`.
- R13: Index 23 stores the guest identifier and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_port | input | 2 | 0 index, 1 value, 2 firmware mailbox |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| sync_done | input | 1 | Display engine finished a sync request |
| mode_enable | output | 1 | Adapter mode enabled |
| mode_configured | output | 1 | Command memory configured |
| mode_width | output | 12 | Current width |
| mode_height | output | 12 | Current height |
| id_version | output | 2 | Negotiated interface version |
| guest_id | output | 32 | Guest identifier |
| cursor_id | output | 32 | Cursor identifier |
| cursor_x | output | 32 | Cursor column |
| cursor_y | output | 32 | Cursor row |
| cursor_visible | output | 1 | Cursor shown |
| cursor_update | output | 1 | One-cycle pulse on a hide or show write |
| sync_busy | output | 1 | Sync request pending |
| reg_error | output | 1 | Sticky bad-index flag |

## Verification
The assertions check four things on every cycle: width and height stay within their limits and change only on a write, the cursor visible flag never moves without an update pulse, busy rises only after a value-port write, and the error flag never drops outside reset. Only the bench scenarios can show that the read values are correct. These include version negotiation with rejected identifiers, boundary acceptance of width and height, the depth translation, the pitch value, and scratch storage at both ends of the bank. The bench also covers the three-way cursor encoding, where values 2 and 3 must leave the flag alone.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

  localparam logic [31:0] ID_BASE = 32'h9000_0000;

  localparam logic [1:0] PORT_INDEX = 2'd0;
  localparam logic [1:0] PORT_VALUE = 2'd1;
  localparam logic [1:0] PORT_FWBOX = 2'd2;

  localparam logic [31:0] IX_ID      = 32'd0;
  localparam logic [31:0] IX_ENABLE  = 32'd1;
  localparam logic [31:0] IX_WIDTH   = 32'd2;
  localparam logic [31:0] IX_HEIGHT  = 32'd3;
  localparam logic [31:0] IX_MAXW    = 32'd4;
  localparam logic [31:0] IX_MAXH    = 32'd5;
  localparam logic [31:0] IX_DEPTH   = 32'd6;
  localparam logic [31:0] IX_BPP     = 32'd7;
  localparam logic [31:0] IX_PITCH   = 32'd12;
  localparam logic [31:0] IX_CAPS    = 32'd17;
  localparam logic [31:0] IX_CFG     = 32'd20;
  localparam logic [31:0] IX_SYNC    = 32'd21;
  localparam logic [31:0] IX_BUSY    = 32'd22;
  localparam logic [31:0] IX_GUEST   = 32'd23;
  localparam logic [31:0] IX_CUR_ID  = 32'd24;
  localparam logic [31:0] IX_CUR_X   = 32'd25;
  localparam logic [31:0] IX_CUR_Y   = 32'd26;
  localparam logic [31:0] IX_CUR_ON  = 32'd27;
  localparam logic [31:0] IX_PAL_LO  = 32'd1024;
  localparam logic [31:0] IX_PAL_HI  = 32'd1791;
  localparam logic [31:0] IX_SCR_LO  = 32'd1792;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_ID, SEL_ENABLE, SEL_WIDTH, SEL_HEIGHT, SEL_MAXW, SEL_MAXH,
    SEL_DEPTH, SEL_BPP, SEL_PITCH, SEL_CAPS, SEL_CFG, SEL_SYNC, SEL_BUSY,
    SEL_GUEST, SEL_CUR_ID, SEL_CUR_X, SEL_CUR_Y, SEL_CUR_ON, SEL_PAL, SEL_SCR
  } reg_sel_e;

  typedef enum logic [1:0] {
    CF_ID = 2'd0, CF_X = 2'd1, CF_Y = 2'd2, CF_ON = 2'd3
  } cur_field_e;

  function automatic logic id_acceptable(input logic [31:0] v);
    return (v == (ID_BASE | 32'd0)) || (v == (ID_BASE | 32'd1)) ||
           (v == (ID_BASE | 32'd2));
  endfunction

endpackage

// File: rtl/dispreg_decode.sv
module dispreg_decode
  import dispreg_pkg::*;
#(
  parameter int SCRATCH_SIZE = 16,
  localparam int SCR_AW = (SCRATCH_SIZE > 1) ? $clog2(SCRATCH_SIZE) : 1
) (
  input  logic [31:0]       index_i,
  output reg_sel_e          sel_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic [SCR_AW-1:0] scr_addr_o
);

  localparam logic [31:0] SCR_END = IX_SCR_LO + 32'(SCRATCH_SIZE);

  logic [31:0] scr_off;

  assign scr_off    = index_i - IX_SCR_LO;
  assign scr_addr_o = scr_off[SCR_AW-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    case (index_i)
      IX_ID:     sel_o = SEL_ID;
      IX_ENABLE: sel_o = SEL_ENABLE;
      IX_WIDTH:  sel_o = SEL_WIDTH;
      IX_HEIGHT: sel_o = SEL_HEIGHT;
      IX_MAXW:   sel_o = SEL_MAXW;
      IX_MAXH:   sel_o = SEL_MAXH;
      IX_DEPTH:  sel_o = SEL_DEPTH;
      IX_BPP:    sel_o = SEL_BPP;
      IX_PITCH:  sel_o = SEL_PITCH;
      IX_CAPS:   sel_o = SEL_CAPS;
      IX_CFG:    sel_o = SEL_CFG;
      IX_SYNC:   sel_o = SEL_SYNC;
      IX_BUSY:   sel_o = SEL_BUSY;
      IX_GUEST:  sel_o = SEL_GUEST;
      IX_CUR_ID: sel_o = SEL_CUR_ID;
      IX_CUR_X:  sel_o = SEL_CUR_X;
      IX_CUR_Y:  sel_o = SEL_CUR_Y;
      IX_CUR_ON: sel_o = SEL_CUR_ON;
      default: begin
        if (index_i >= IX_PAL_LO && index_i <= IX_PAL_HI) begin
          sel_o = SEL_PAL;
        end else if (index_i >= IX_SCR_LO && index_i < SCR_END) begin
          sel_o = SEL_SCR;
        end
      end
    endcase
  end

  always_comb begin
    rd_ok_o = (sel_o != SEL_NONE);
    case (sel_o)
      SEL_NONE, SEL_MAXW, SEL_MAXH, SEL_PITCH, SEL_CAPS, SEL_BUSY: wr_ok_o = 1'b0;
      default: wr_ok_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/dispreg_scratch.sv
module dispreg_scratch #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] word_view [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] q;
    logic              en;
    assign en = we_i && (addr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wdata_i;
      end
    end
    assign word_view[g] = q;
  end

  assign rdata_o = word_view[addr_i];

endmodule

// File: rtl/dispreg_cursor.sv
module dispreg_cursor
  import dispreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  cur_field_e        field_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] id_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic              visible_o,
  output logic              update_o
);

  logic [DATA_W-1:0] id_q, id_d, x_q, x_d, y_q, y_d;
  logic              vis_q, vis_d, upd_q, upd_d;
  logic              is_hide, is_show;

  assign is_hide = (wdata_i == DATA_W'(0));
  assign is_show = (wdata_i == DATA_W'(1));

  always_comb begin
    id_d  = id_q;
    x_d   = x_q;
    y_d   = y_q;
    vis_d = vis_q;
    upd_d = 1'b0;
    if (we_i) begin
      case (field_i)
        CF_ID: id_d = wdata_i;
        CF_X:  x_d  = wdata_i;
        CF_Y:  y_d  = wdata_i;
        CF_ON: begin
          if (is_hide || is_show) begin
            vis_d = is_show;
            upd_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      x_q   <= '0;
      y_q   <= '0;
      vis_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      x_q   <= x_d;
      y_q   <= y_d;
      vis_q <= vis_d;
      upd_q <= upd_d;
    end
  end

  assign id_o      = id_q;
  assign x_o       = x_q;
  assign y_o       = y_q;
  assign visible_o = vis_q;
  assign update_o  = upd_q;

endmodule

// File: rtl/dispreg_port.sv
module dispreg_port
  import dispreg_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DIM_W        = 12,
  parameter int MAX_WIDTH    = 2368,
  parameter int MAX_HEIGHT   = 1770,
  parameter int RESET_WIDTH  = 640,
  parameter int RESET_HEIGHT = 480,
  parameter int HOST_DEPTH   = 32,
  parameter int SCRATCH_SIZE = 16,
  parameter bit CURSOR_CAPS  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_port,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              sync_done,
  output logic              mode_enable,
  output logic              mode_configured,
  output logic [DIM_W-1:0]  mode_width,
  output logic [DIM_W-1:0]  mode_height,
  output logic [1:0]        id_version,
  output logic [DATA_W-1:0] guest_id,
  output logic [DATA_W-1:0] cursor_id,
  output logic [DATA_W-1:0] cursor_x,
  output logic [DATA_W-1:0] cursor_y,
  output logic              cursor_visible,
  output logic              cursor_update,
  output logic              sync_busy,
  output logic              reg_error
);

  localparam int SCR_AW = (SCRATCH_SIZE > 1) ? $clog2(SCRATCH_SIZE) : 1;
  localparam logic [DATA_W-1:0] DEPTH_SHOWN =
    DATA_W'((HOST_DEPTH == 32) ? 24 : HOST_DEPTH);
  localparam logic [DATA_W-1:0] CAPS_BASE   = DATA_W'(32'h0000_0003);
  localparam logic [DATA_W-1:0] CAPS_CURSOR = DATA_W'(32'h0000_00E0);
  localparam logic [DATA_W-1:0] MAXW_V = DATA_W'(MAX_WIDTH);
  localparam logic [DATA_W-1:0] MAXH_V = DATA_W'(MAX_HEIGHT);

  logic [DATA_W-1:0] caps_word;
  if (CURSOR_CAPS) begin : g_caps_cur
    assign caps_word = CAPS_BASE | CAPS_CURSOR;
  end else begin : g_caps_plain
    assign caps_word = CAPS_BASE;
  end

  // ---------------- state ----------------
  logic [DATA_W-1:0] index_q, index_d;
  logic [31:0]       id_q, id_d;
  logic              enable_q, enable_d;
  logic              cfg_q, cfg_d;
  logic [DIM_W-1:0]  width_q, width_d;
  logic [DIM_W-1:0]  height_q, height_d;
  logic [DATA_W-1:0] guest_q, guest_d;
  logic              busy_q, busy_d;
  logic              err_q, err_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_q, rsp_d;

  // ---------------- access strobes ----------------
  logic wr_index, wr_value, rd_value, rd_any;
  assign wr_index = bus_valid &&  bus_write && (bus_port == PORT_INDEX);
  assign wr_value = bus_valid &&  bus_write && (bus_port == PORT_VALUE);
  assign rd_value = bus_valid && !bus_write && (bus_port == PORT_VALUE);
  assign rd_any   = bus_valid && !bus_write;

  // ---------------- decode ----------------
  reg_sel_e          sel;
  logic              rd_ok, wr_ok;
  logic [SCR_AW-1:0] scr_addr;

  dispreg_decode #(.SCRATCH_SIZE(SCRATCH_SIZE)) u_decode (
    .index_i   (32'(index_q)),
    .sel_o     (sel),
    .rd_ok_o   (rd_ok),
    .wr_ok_o   (wr_ok),
    .scr_addr_o(scr_addr)
  );

  // ---------------- scratch bank ----------------
  logic              scr_we;
  logic [DATA_W-1:0] scr_rdata;
  assign scr_we = wr_value && (sel == SEL_SCR);

  dispreg_scratch #(.DATA_W(DATA_W), .DEPTH(SCRATCH_SIZE)) u_scratch (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (scr_we),
    .addr_i (scr_addr),
    .wdata_i(bus_wdata),
    .rdata_o(scr_rdata)
  );

  // ---------------- cursor ----------------
  logic       cur_we;
  cur_field_e cur_field;
  logic       cur_vis;

  always_comb begin
    cur_we    = 1'b0;
    cur_field = CF_ID;
    case (sel)
      SEL_CUR_ID: begin cur_we = wr_value; cur_field = CF_ID; end
      SEL_CUR_X:  begin cur_we = wr_value; cur_field = CF_X;  end
      SEL_CUR_Y:  begin cur_we = wr_value; cur_field = CF_Y;  end
      SEL_CUR_ON: begin cur_we = wr_value; cur_field = CF_ON; end
      default: ;
    endcase
  end

  dispreg_cursor #(.DATA_W(DATA_W)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cur_we),
    .field_i  (cur_field),
    .wdata_i  (bus_wdata),
    .id_o     (cursor_id),
    .x_o      (cursor_x),
    .y_o      (cursor_y),
    .visible_o(cur_vis),
    .update_o (cursor_update)
  );
  assign cursor_visible = cur_vis;

  // ---------------- read mux ----------------
  logic [DATA_W-1:0] pitch_w;
  logic [DATA_W-1:0] value_rd;
  logic [DATA_W-1:0] port_rd;

  assign pitch_w = (DATA_W'(width_q) * DATA_W'(HOST_DEPTH)) >> 3;

  always_comb begin
    case (sel)
      SEL_ID:     value_rd = DATA_W'(id_q);
      SEL_ENABLE: value_rd = DATA_W'(enable_q);
      SEL_WIDTH:  value_rd = DATA_W'(width_q);
      SEL_HEIGHT: value_rd = DATA_W'(height_q);
      SEL_MAXW:   value_rd = MAXW_V;
      SEL_MAXH:   value_rd = MAXH_V;
      SEL_DEPTH:  value_rd = DEPTH_SHOWN;
      SEL_BPP:    value_rd = DATA_W'(HOST_DEPTH);
      SEL_PITCH:  value_rd = pitch_w;
      SEL_CAPS:   value_rd = caps_word;
      SEL_CFG:    value_rd = DATA_W'(cfg_q);
      SEL_SYNC,
      SEL_BUSY:   value_rd = DATA_W'(busy_q);
      SEL_GUEST:  value_rd = guest_q;
      SEL_CUR_ID: value_rd = cursor_id;
      SEL_CUR_X:  value_rd = cursor_x;
      SEL_CUR_Y:  value_rd = cursor_y;
      SEL_CUR_ON: value_rd = DATA_W'(cur_vis);
      SEL_SCR:    value_rd = scr_rdata;
      default:    value_rd = '0;
    endcase
  end

  always_comb begin
    case (bus_port)
      PORT_INDEX: port_rd = index_q;
      PORT_VALUE: port_rd = value_rd;
      PORT_FWBOX: port_rd = '0;
      default:    port_rd = '1;
    endcase
  end

  // ---------------- next state ----------------
  always_comb begin
    index_d  = index_q;
    id_d     = id_q;
    enable_d = enable_q;
    cfg_d    = cfg_q;
    width_d  = width_q;
    height_d = height_q;
    guest_d  = guest_q;
    busy_d   = busy_q;
    err_d    = err_q;
    rsp_v_d  = rd_any;
    rsp_d    = rd_any ? port_rd : rsp_q;

    if (wr_index) begin
      index_d = bus_wdata;
    end

    if (sync_done) begin
      busy_d = 1'b0;
    end

    if (wr_value && wr_ok) begin
      case (sel)
        SEL_ID:     if (id_acceptable(32'(bus_wdata))) id_d = 32'(bus_wdata);
        SEL_ENABLE: enable_d = (bus_wdata != '0);
        SEL_WIDTH:  if (bus_wdata <= MAXW_V) width_d  = DIM_W'(bus_wdata);
        SEL_HEIGHT: if (bus_wdata <= MAXH_V) height_d = DIM_W'(bus_wdata);
        SEL_CFG:    cfg_d = (bus_wdata != '0);
        SEL_SYNC:   if (bus_wdata != '0) busy_d = 1'b1;
        SEL_GUEST:  guest_d = bus_wdata;
        default: ;
      endcase
    end

    if ((rd_value && !rd_ok) || (wr_value && !wr_ok)) begin
      err_d = 1'b1;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      id_q     <= ID_BASE | 32'd2;
      enable_q <= 1'b0;
      cfg_q    <= 1'b0;
      width_q  <= DIM_W'(RESET_WIDTH);
      height_q <= DIM_W'(RESET_HEIGHT);
      guest_q  <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_q    <= '0;
    end else begin
      index_q  <= index_d;
      id_q     <= id_d;
      enable_q <= enable_d;
      cfg_q    <= cfg_d;
      width_q  <= width_d;
      height_q <= height_d;
      guest_q  <= guest_d;
      busy_q   <= busy_d;
      err_q    <= err_d;
      rsp_v_q  <= rsp_v_d;
      rsp_q    <= rsp_d;
    end
  end

  assign rsp_valid       = rsp_v_q;
  assign rsp_data        = rsp_q;
  assign mode_enable     = enable_q;
  assign mode_configured = cfg_q;
  assign mode_width      = width_q;
  assign mode_height     = height_q;
  assign id_version      = id_q[1:0];
  assign guest_id        = guest_q;
  assign sync_busy       = busy_q;
  assign reg_error       = err_q;

endmodule

// File: rtl/dispreg_port_chk.sv
module dispreg_port_chk #(
  parameter int DIM_W      = 12,
  parameter int MAX_WIDTH  = 2368,
  parameter int MAX_HEIGHT = 1770
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       bus_port,
  input logic             rsp_valid,
  input logic             sync_busy,
  input logic [DIM_W-1:0] mode_width,
  input logic [DIM_W-1:0] mode_height,
  input logic             cursor_visible,
  input logic             cursor_update,
  input logic             reg_error
);

  logic value_wr;
  assign value_wr = bus_valid && bus_write && (bus_port == 2'd1);

  assert_width_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mode_width) <= 32'(MAX_WIDTH));

  assert_height_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mode_height) <= 32'(MAX_HEIGHT));

  assert_dims_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !value_wr |=> ($stable(mode_width) && $stable(mode_height)));

  assert_read_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !bus_write));

  assert_busy_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_busy) |-> $past(value_wr));

  assert_cursor_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cursor_visible) |-> cursor_update);

  assert_error_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(reg_error));

endmodule

bind dispreg_port dispreg_port_chk #(
  .DIM_W     (DIM_W),
  .MAX_WIDTH (MAX_WIDTH),
  .MAX_HEIGHT(MAX_HEIGHT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_port      (bus_port),
  .rsp_valid     (rsp_valid),
  .sync_busy     (sync_busy),
  .mode_width    (mode_width),
  .mode_height   (mode_height),
  .cursor_visible(cursor_visible),
  .cursor_update (cursor_update),
  .reg_error     (reg_error)
);

// File: tb/dispreg_port_test.sv
module dispreg_port_test;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [1:0]  bus_port;
  logic [31:0] bus_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        sync_done;
  logic        mode_enable, mode_configured;
  logic [11:0] mode_width, mode_height;
  logic [1:0]  id_version;
  logic [31:0] guest_id, cursor_id, cursor_x, cursor_y;
  logic        cursor_visible, cursor_update, sync_busy, reg_error;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dispreg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sync_done(sync_done), .mode_enable(mode_enable),
    .mode_configured(mode_configured), .mode_width(mode_width),
    .mode_height(mode_height), .id_version(id_version), .guest_id(guest_id),
    .cursor_id(cursor_id), .cursor_x(cursor_x), .cursor_y(cursor_y),
    .cursor_visible(cursor_visible), .cursor_update(cursor_update),
    .sync_busy(sync_busy), .reg_error(reg_error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: {is_write, port, data, expected}
  function automatic logic [66:0] vw(input logic [1:0] p, input logic [31:0] d);
    return {1'b1, p, d, 32'd0};
  endfunction
  function automatic logic [66:0] vr(input logic [1:0] p, input logic [31:0] e);
    return {1'b0, p, 32'd0, e};
  endfunction

  localparam int NV = 61;
  localparam logic [66:0] VEC [NV] = '{
    vw(0, 0),            vr(1, 32'h9000_0002),  // R1 R3 reset id
    vw(1, 32'h9000_0001), vr(1, 32'h9000_0001), // R3 accepted
    vw(1, 32'h1234_5678), vr(1, 32'h9000_0001), // R3 rejected
    vw(1, 32'h9000_0000), vr(1, 32'h9000_0000), // R3
    vw(1, 32'h9000_0003), vr(1, 32'h9000_0000), // R3 rejected
    vr(0, 0),                                   // R2 index readback
    vw(0, 2), vw(1, 800), vr(1, 800),           // R4
    vw(1, 2368), vr(1, 2368),                   // R4 boundary kept
    vw(1, 2369), vr(1, 2368),                   // R4 over limit dropped
    vw(0, 3), vr(1, 480),                       // R1 reset height
    vw(1, 1770), vr(1, 1770),                   // R4
    vw(1, 1771), vr(1, 1770),                   // R4
    vw(0, 12), vr(1, 9472),                     // R6 pitch 32*2368/8
    vw(0, 6), vr(1, 24), vw(1, 8), vr(1, 24),   // R5 depth
    vw(0, 7), vr(1, 32), vw(1, 16), vr(1, 32),  // R5 bpp
    vw(0, 17), vr(1, 32'hE3),                   // R7 caps
    vw(0, 4), vr(1, 2368),                      // R7
    vw(0, 5), vr(1, 1770),                      // R7
    vw(0, 23), vw(1, 5005), vr(1, 5005),        // R13
    vw(0, 1025), vw(1, 32'hABCD), vr(1, 0),     // R11 palette
    vw(0, 1792), vw(1, 32'h1111_1111),          // R11 scratch
    vw(0, 1793), vw(1, 32'h2222_2222),
    vw(0, 1792), vr(1, 32'h1111_1111),
    vw(0, 1807), vw(1, 32'hFFFF_0000), vr(1, 32'hFFFF_0000), // R11 last word
    vw(0, 1793), vr(1, 32'h2222_2222),
    vr(2, 0), vw(2, 5), vr(0, 1793),            // R2 mailbox
    vr(3, 32'hFFFF_FFFF)                        // R2 port 3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] p, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_port = p; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] p, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_port = p;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] d;
    bus_valid = 0; bus_write = 0; bus_port = 0; bus_wdata = 0; sync_done = 0;
    do_reset();

    check("R1 width", 32'(mode_width), 640);
    check("R1 height", 32'(mode_height), 480);
    check("R1 flags", {27'd0, mode_enable, mode_configured, sync_busy,
                       cursor_visible, reg_error}, 0);
    check("R1 version", 32'(id_version), 2);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][66]) begin
        do_write(VEC[i][65:64], VEC[i][63:32]);
      end else begin
        do_read(VEC[i][65:64], d);
        check($sformatf("vector %0d", i), d, VEC[i][31:0]);
      end
    end

    check("R11 palette no error", 32'(reg_error), 0);
    check("R4 width port", 32'(mode_width), 2368);
    check("R3 version port", 32'(id_version), 0);

    // R8 enable and configured
    do_write(0, 1); do_write(1, 7);
    check("R8 enable", 32'(mode_enable), 1);
    do_read(1, d); check("R8 enable read", d, 1);
    do_write(0, 20); do_write(1, 1);
    check("R8 configured", 32'(mode_configured), 1);
    do_write(1, 0);
    check("R8 configured clear", 32'(mode_configured), 0);

    // R9 sync handshake
    do_write(0, 21); do_write(1, 1);
    check("R9 busy set", 32'(sync_busy), 1);
    do_write(0, 22); do_read(1, d);
    check("R9 busy read", d, 1);
    @(negedge clk); sync_done = 1'b1;
    @(negedge clk); sync_done = 1'b0;
    check("R9 busy cleared", 32'(sync_busy), 0);
    do_read(1, d); check("R9 busy read clear", d, 0);

    // R10 cursor
    do_write(0, 24); do_write(1, 9);
    do_write(0, 25); do_write(1, 100);
    do_write(0, 26); do_write(1, 200);
    check("R10 cursor id", cursor_id, 9);
    check("R10 cursor x", cursor_x, 100);
    check("R10 cursor y", cursor_y, 200);
    do_write(0, 27); do_write(1, 1);
    check("R10 show pulse", {cursor_visible, cursor_update}, 2'b11);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(cursor_update), 0);
    do_write(1, 2);
    check("R10 value 2 no effect", {cursor_visible, cursor_update}, 2'b10);
    do_write(1, 3);
    check("R10 value 3 no effect", {cursor_visible, cursor_update}, 2'b10);
    do_write(1, 0);
    check("R10 hide pulse", {cursor_visible, cursor_update}, 2'b01);
    do_write(1, 2);
    check("R10 value 2 stays hidden", {cursor_visible, cursor_update}, 2'b00);
    check("R12 no error yet", 32'(reg_error), 0);

    // R12 unmapped accesses
    do_write(0, 1808); do_read(1, d);
    check("R12 beyond scratch reads 0", d, 0);
    check("R12 error set", 32'(reg_error), 1);
    do_write(0, 5); do_write(1, 1);
    check("R12 error sticky", 32'(reg_error), 1);
    do_reset();
    check("R12 reset clears", 32'(reg_error), 0);
    do_write(0, 9); do_write(1, 1);
    check("R12 unmapped write", 32'(reg_error), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule